// File: doc/BRIEF.md
# Fault Trip Guard for PWM Outputs

This block sits between a PWM waveform generator and the output pins. It watches six active-low fault inputs. When a fault that software has enabled occurs, it overrides the PWM outputs with a programmed safe action. Each fault input can be enabled for two trip types, and each type releases in its own way:

- A sticky trip holds until software clears it.
- A per-cycle trip releases by itself at the next counter-zero pulse once the fault has gone away.

The fault pins are asynchronous. Each passes through a two-flop synchronizer before it is used. Software can also raise either trip type directly with a force strobe.

The block keeps three latched flags: sticky, per-cycle and interrupt summary. Each flag has its own clear strobe. Each trip type has its own interrupt enable. A single-cycle interrupt pulse is produced only when the summary flag goes from clear to set. Each output has a 2-bit action:

- drive low;
- drive high;
- leave the PWM value through;
- release the pin to high impedance, shown by an output-enable driven low.

Top module: `fault_trip_guard`

## Requirements
- R1: After reset all flags and irq_o are 0, every pwm_oe_o bit is 1 and pwm_o equals pwm_i. A fault pin driven low is seen by the trip logic after two synchronizer stages, so the override appears after the third rising clock edge following the change.
- R2: A fault pin enabled in sel_os_i sets the sticky trip and os_flag_o. Both stay set after the pin returns high, until a clr_os_i strobe.
- R3: A fault pin enabled in sel_cyc_i sets the per-cycle trip. The trip is released at the first cnt_zero_i pulse that comes while no enabled per-cycle source is active. A cnt_zero_i pulse while the source is still active does not release it.
- R4: cyc_flag_o is set by a per-cycle trip and stays set across cnt_zero_i pulses. It is cleared only by clr_cyc_i.
- R5: A fault pin with neither its sel_os_i bit nor its sel_cyc_i bit set has no effect on the outputs or the flags.
- R6: While tripped, output k obeys act_i[2k+1:2k]:
  - 00 sets pwm_oe_o[k]=0 and pwm_o[k]=0 (high impedance);
  - 01 forces pwm_o[k]=1;
  - 10 forces pwm_o[k]=0;
  - 11 passes pwm_i[k].
- R7: While neither trip is active, pwm_o equals pwm_i and pwm_oe_o is all ones, whatever act_i holds.
- R8: irq_flag_o is set by a sticky trip when irq_en_os_i is 1, or by a per-cycle trip when irq_en_cyc_i is 1. irq_o is high for exactly the one cycle in which irq_flag_o goes from 0 to 1. A trip whose type is not enabled leaves irq_flag_o at 0.
- R9: While irq_flag_o stays set, further trips raise no new irq_o pulse. After a clr_irq_i strobe, the next enabled trip pulses irq_o again.
- R10: A force_os_i strobe sets the sticky trip and a force_cyc_i strobe sets the per-cycle trip, both in the following cycle, with no synchronizer delay.
- R11: When a set condition and the matching clear strobe coincide, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_ni | input | 6 | Asynchronous fault pins, active low |
| sel_os_i | input | 6 | Per-pin enable for the sticky trip |
| sel_cyc_i | input | 6 | Per-pin enable for the per-cycle trip |
| act_i | input | 4 | Trip action, two bits per output, output k at [2k+1:2k] |
| irq_en_os_i | input | 1 | Interrupt enable for sticky trips |
| irq_en_cyc_i | input | 1 | Interrupt enable for per-cycle trips |
| force_os_i | input | 1 | Strobe: force a sticky trip |
| force_cyc_i | input | 1 | Strobe: force a per-cycle trip |
| clr_os_i | input | 1 | Strobe: clear the sticky trip and its flag |
| clr_cyc_i | input | 1 | Strobe: clear the per-cycle flag |
| clr_irq_i | input | 1 | Strobe: clear the interrupt summary flag |
| cnt_zero_i | input | 1 | Pulse when the PWM time-base counter equals zero |
| pwm_i | input | 2 | PWM waveform from the generator |
| pwm_o | output | 2 | Guarded PWM data |
| pwm_oe_o | output | 2 | Output enable, 0 means high impedance |
| os_flag_o | output | 1 | Sticky trip flag |
| cyc_flag_o | output | 1 | Per-cycle trip flag |
| irq_flag_o | output | 1 | Interrupt summary flag |
| irq_o | output | 1 | Single-cycle interrupt pulse |

## Verification
Each kind of wrong internal state shows at the ports within a few cycles:

- A stuck or missing per-cycle latch shows on pwm_o on the cycle after a cnt_zero_i pulse, as either a release that should not happen or a trip that never ends.
- A wrong synchronizer depth moves the override by one cycle, so the override is sampled at exactly the second and third edge after the fault pin falls.
- A lost set-over-clear priority or edge detection on the summary flag shows as a missing or repeated irq_o in the cycle after the trip.
- A mis-decoded action field shows immediately on pwm_o and pwm_oe_o while the block is held tripped.

// File: rtl/trip_guard_pkg.sv
package trip_guard_pkg;
  typedef enum logic [1:0] {
    ACT_HIZ  = 2'b00,
    ACT_HIGH = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_KEEP = 2'b11
  } trip_act_e;
endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_ni,
  output logic [W-1:0] sync_no
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= async_ni;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_no = stage_q[STAGES-1];
endmodule

// File: rtl/trip_latches.sv
module trip_latches #(
  parameter int NUM_IN = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] fault_i,
  input  logic [NUM_IN-1:0] sel_os_i,
  input  logic [NUM_IN-1:0] sel_cyc_i,
  input  logic              force_os_i,
  input  logic              force_cyc_i,
  input  logic              cnt_zero_i,
  input  logic              clr_os_i,
  input  logic              clr_cyc_i,
  input  logic              clr_irq_i,
  input  logic              irq_en_os_i,
  input  logic              irq_en_cyc_i,
  output logic              tripped_o,
  output logic              os_flag_o,
  output logic              cyc_flag_o,
  output logic              irq_flag_o,
  output logic              irq_o
);
  logic os_hit, cyc_hit, irq_set;
  logic os_q, cyc_trip_q, cyc_flag_q, irq_flag_q, irq_q;

  assign os_hit  = |(fault_i & sel_os_i) | force_os_i;
  assign cyc_hit = |(fault_i & sel_cyc_i) | force_cyc_i;
  assign irq_set = (os_hit & irq_en_os_i) | (cyc_hit & irq_en_cyc_i);

  // set has priority over every release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      os_q       <= 1'b0;
      cyc_trip_q <= 1'b0;
      cyc_flag_q <= 1'b0;
      irq_flag_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (os_hit)        os_q <= 1'b1;
      else if (clr_os_i) os_q <= 1'b0;

      if (cyc_hit)         cyc_trip_q <= 1'b1;
      else if (cnt_zero_i) cyc_trip_q <= 1'b0;

      if (cyc_hit)        cyc_flag_q <= 1'b1;
      else if (clr_cyc_i) cyc_flag_q <= 1'b0;

      if (irq_set)        irq_flag_q <= 1'b1;
      else if (clr_irq_i) irq_flag_q <= 1'b0;

      irq_q <= irq_set & ~irq_flag_q;
    end
  end

  assign tripped_o  = os_q | cyc_trip_q;
  assign os_flag_o  = os_q;
  assign cyc_flag_o = cyc_flag_q;
  assign irq_flag_o = irq_flag_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/trip_override.sv
module trip_override
  import trip_guard_pkg::*;
(
  input  logic       tripped_i,
  input  logic [1:0] act_i,
  input  logic       pwm_i,
  output logic       pwm_o,
  output logic       oe_o
);
  always_comb begin
    pwm_o = pwm_i;
    oe_o  = 1'b1;
    if (tripped_i) begin
      unique case (trip_act_e'(act_i))
        ACT_HIZ:  begin pwm_o = 1'b0; oe_o = 1'b0; end
        ACT_HIGH: pwm_o = 1'b1;
        ACT_LOW:  pwm_o = 1'b0;
        ACT_KEEP: pwm_o = pwm_i;
        default:  pwm_o = pwm_i;
      endcase
    end
  end
endmodule

// File: rtl/fault_trip_guard.sv
module fault_trip_guard #(
  parameter int NUM_IN      = 6,
  parameter int NUM_OUT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_IN-1:0]    fault_ni,
  input  logic [NUM_IN-1:0]    sel_os_i,
  input  logic [NUM_IN-1:0]    sel_cyc_i,
  input  logic [2*NUM_OUT-1:0] act_i,
  input  logic                 irq_en_os_i,
  input  logic                 irq_en_cyc_i,
  input  logic                 force_os_i,
  input  logic                 force_cyc_i,
  input  logic                 clr_os_i,
  input  logic                 clr_cyc_i,
  input  logic                 clr_irq_i,
  input  logic                 cnt_zero_i,
  input  logic [NUM_OUT-1:0]   pwm_i,
  output logic [NUM_OUT-1:0]   pwm_o,
  output logic [NUM_OUT-1:0]   pwm_oe_o,
  output logic                 os_flag_o,
  output logic                 cyc_flag_o,
  output logic                 irq_flag_o,
  output logic                 irq_o
);
  logic [NUM_IN-1:0] fault_sync_n;
  logic              tripped;

  trip_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_ni (fault_ni),
    .sync_no  (fault_sync_n)
  );

  trip_latches #(.NUM_IN(NUM_IN)) u_latch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fault_i      (~fault_sync_n),
    .sel_os_i     (sel_os_i),
    .sel_cyc_i    (sel_cyc_i),
    .force_os_i   (force_os_i),
    .force_cyc_i  (force_cyc_i),
    .cnt_zero_i   (cnt_zero_i),
    .clr_os_i     (clr_os_i),
    .clr_cyc_i    (clr_cyc_i),
    .clr_irq_i    (clr_irq_i),
    .irq_en_os_i  (irq_en_os_i),
    .irq_en_cyc_i (irq_en_cyc_i),
    .tripped_o    (tripped),
    .os_flag_o    (os_flag_o),
    .cyc_flag_o   (cyc_flag_o),
    .irq_flag_o   (irq_flag_o),
    .irq_o        (irq_o)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    trip_override u_ovr (
      .tripped_i (tripped),
      .act_i     (act_i[2*k+1:2*k]),
      .pwm_i     (pwm_i[k]),
      .pwm_o     (pwm_o[k]),
      .oe_o      (pwm_oe_o[k])
    );
  end
endmodule

// File: rtl/fault_trip_guard_chk.sv
module fault_trip_guard_chk #(
  parameter int NUM_OUT = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tripped,
  input logic               force_os_i,
  input logic               clr_os_i,
  input logic               clr_irq_i,
  input logic [NUM_OUT-1:0] pwm_i,
  input logic [NUM_OUT-1:0] pwm_o,
  input logic [NUM_OUT-1:0] pwm_oe_o,
  input logic               os_flag_o,
  input logic               irq_flag_o,
  input logic               irq_o
);
  // R2
  os_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    os_flag_o && !clr_os_i |=> os_flag_o);

  // R7
  pass_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tripped |-> (pwm_o == pwm_i) && (pwm_oe_o == '1));

  // R8
  irq_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_flag_o ##1 !irq_o);

  // R9
  irq_on_rise_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(irq_flag_o));

  // R9
  irq_flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_flag_o && !clr_irq_i |=> irq_flag_o);

  // R10
  force_os_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_os_i |=> os_flag_o && tripped);
endmodule

bind fault_trip_guard fault_trip_guard_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tripped    (tripped),
  .force_os_i (force_os_i),
  .clr_os_i   (clr_os_i),
  .clr_irq_i  (clr_irq_i),
  .pwm_i      (pwm_i),
  .pwm_o      (pwm_o),
  .pwm_oe_o   (pwm_oe_o),
  .os_flag_o  (os_flag_o),
  .irq_flag_o (irq_flag_o),
  .irq_o      (irq_o)
);

// File: tb/fault_trip_guard_test.sv
module fault_trip_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IN     = 6;
  localparam int NUM_OUT    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_IN-1:0] fault_n = '1, sel_os = '0, sel_cyc = '0;
  logic [2*NUM_OUT-1:0] act = '1;
  logic irq_en_os = 0, irq_en_cyc = 0, force_os = 0, force_cyc = 0;
  logic clr_os = 0, clr_cyc = 0, clr_irq = 0, cnt_zero = 0;
  logic [NUM_OUT-1:0] pwm_in = '0;
  logic [NUM_OUT-1:0] pwm_out, pwm_oe;
  logic os_flag, cyc_flag, irq_flag, irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_trip_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .fault_ni(fault_n), .sel_os_i(sel_os),
    .sel_cyc_i(sel_cyc), .act_i(act), .irq_en_os_i(irq_en_os),
    .irq_en_cyc_i(irq_en_cyc), .force_os_i(force_os), .force_cyc_i(force_cyc),
    .clr_os_i(clr_os), .clr_cyc_i(clr_cyc), .clr_irq_i(clr_irq),
    .cnt_zero_i(cnt_zero), .pwm_i(pwm_in), .pwm_o(pwm_out), .pwm_oe_o(pwm_oe),
    .os_flag_o(os_flag), .cyc_flag_o(cyc_flag), .irq_flag_o(irq_flag), .irq_o(irq)
  );

  task automatic check(string req, string what, logic [31:0] actual, logic [31:0] expected);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_os = 1; clr_cyc = 1; clr_irq = 1; cnt_zero = 1;
    step(1);
    clr_os = 0; clr_cyc = 0; clr_irq = 0; cnt_zero = 0;
    step(1);
  endtask

  task automatic t_reset();
    pwm_in = 2'b10; #1;
    check("R1", "os_flag", os_flag, 0);
    check("R1", "cyc_flag", cyc_flag, 0);
    check("R1", "irq_flag", irq_flag, 0);
    check("R1", "irq", irq, 0);
    check("R7", "oe", pwm_oe, 2'b11);
    check("R7", "pass", pwm_out, 2'b10);
  endtask

  task automatic t_oneshot_latency();
    sel_os = 6'b000100; act = 4'b1110; pwm_in = 2'b01;
    fault_n[2] = 0;
    step(2);
    check("R1", "no trip after 2 edges", pwm_out, 2'b01);
    step(1);
    check("R1", "trip after 3 edges", pwm_out, 2'b00);
    check("R2", "os_flag set", os_flag, 1);
    check("R8", "irq disabled", irq_flag, 0);
    fault_n[2] = 1;
    step(5);
    check("R2", "held after pin release", pwm_out, 2'b00);
    clr_os = 1; step(1); clr_os = 0; #1;
    check("R2", "released by clear", pwm_out, 2'b01);
    check("R2", "os_flag cleared", os_flag, 0);
    sel_os = '0;
  endtask

  task automatic t_cycle();
    sel_cyc = 6'b010000; act = 4'b1101; pwm_in = 2'b00;
    fault_n[4] = 0;
    step(3); #1;
    check("R3", "cycle trip", pwm_out, 2'b01);
    check("R4", "cyc_flag set", cyc_flag, 1);
    cnt_zero = 1; step(1); cnt_zero = 0;
    check("R3", "zero while active keeps trip", pwm_out, 2'b01);
    fault_n[4] = 1;
    step(3);
    check("R3", "held until zero", pwm_out, 2'b01);
    cnt_zero = 1; step(1); cnt_zero = 0;
    check("R3", "released at zero", pwm_out, 2'b00);
    check("R4", "cyc_flag survives zero", cyc_flag, 1);
    clr_cyc = 1; step(1); clr_cyc = 0;
    check("R4", "cyc_flag cleared", cyc_flag, 0);
    sel_cyc = '0;
  endtask

  task automatic t_ignore();
    sel_os = 6'b001000; sel_cyc = 6'b100000; act = 4'b1010; pwm_in = 2'b11;
    fault_n[1] = 0; fault_n[0] = 0;
    step(5); #1;
    check("R5", "disabled pins no effect", pwm_out, 2'b11);
    check("R5", "no os flag", os_flag, 0);
    check("R5", "no cyc flag", cyc_flag, 0);
    fault_n = '1; sel_os = '0; sel_cyc = '0;
    step(3);
  endtask

  task automatic t_actions();
    force_os = 1; step(1); force_os = 0;
    check("R10", "force os flag", os_flag, 1);
    pwm_in = 2'b11; act = 4'b0010; #1;
    check("R6", "A low B hiz data", pwm_out, 2'b00);
    check("R6", "A low B hiz oe", pwm_oe, 2'b01);
    pwm_in = 2'b00; act = 4'b0100; #1;
    check("R6", "A hiz B high data", pwm_out, 2'b10);
    check("R6", "A hiz B high oe", pwm_oe, 2'b10);
    pwm_in = 2'b10; act = 4'b1111; #1;
    check("R6", "keep passes", pwm_out, 2'b10);
    check("R6", "keep oe", pwm_oe, 2'b11);
    pwm_in = 2'b01; #1;
    check("R6", "keep follows", pwm_out, 2'b01);
    clear_all();
    act = 4'b0000; pwm_in = 2'b10; #1;
    check("R7", "idle ignores act data", pwm_out, 2'b10);
    check("R7", "idle ignores act oe", pwm_oe, 2'b11);
  endtask

  task automatic t_force_cycle();
    act = 4'b0101; pwm_in = 2'b00;
    force_cyc = 1; step(1); force_cyc = 0;
    check("R10", "force cyc trip", pwm_out, 2'b11);
    check("R8", "cyc irq disabled", irq_flag, 0);
    cnt_zero = 1; step(1); cnt_zero = 0;
    check("R10", "forced cyc released", pwm_out, 2'b00);
    clear_all();
  endtask

  task automatic t_irq();
    irq_en_os = 1;
    force_os = 1; step(1); force_os = 0;
    check("R8", "irq pulse", irq, 1);
    check("R8", "irq flag", irq_flag, 1);
    step(1);
    check("R8", "pulse one cycle", irq, 0);
    force_os = 1; step(1); force_os = 0;
    check("R9", "no repulse while set", irq, 0);
    step(1);
    check("R9", "still none", irq, 0);
    clr_irq = 1; clr_os = 1; step(1); clr_irq = 0; clr_os = 0;
    check("R9", "flag cleared", irq_flag, 0);
    irq_en_os = 0; irq_en_cyc = 1;
    force_cyc = 1; step(1); force_cyc = 0;
    check("R9", "repulse after clear", irq, 1);
    irq_en_cyc = 0;
    clear_all();
  endtask

  task automatic t_priority();
    force_os = 1; step(1);
    clr_os = 1; step(1); force_os = 0; clr_os = 0;
    check("R11", "set beats clear os", os_flag, 1);
    force_cyc = 1; clr_cyc = 1; step(1); force_cyc = 0; clr_cyc = 0;
    check("R11", "set beats clear cyc", cyc_flag, 1);
    clear_all();
    check("R11", "clears after", os_flag, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_oneshot_latency();
    t_cycle();
    t_ignore();
    t_actions();
    t_force_cycle();
    t_irq();
    t_priority();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule